// File: doc/BRIEF.md
# Servo Command Byte Loader

This block takes a stream of bytes from a host and builds complete servo commands from them in a 64-byte RAM. The first byte of a command carries a 4-bit command code in its upper nibble and, in its lower nibble, the number of parameter bytes that will follow (one to seven). That byte is kept in a fixed command slot. Each parameter byte that arrives is placed one address lower than the last, starting just below the command slot. The parameter count in the stored command word is reduced by one for every parameter, so it shows how many bytes are still to come.

When the count reaches zero, the loader raises a one-cycle completion strobe together with the command code and then waits for a fresh command byte. A command byte with an illegal count is refused and an error flag is raised. An abort input drops any partly loaded command. A synchronous read port lets the surrounding logic, or a test, look at any RAM byte one cycle after presenting its address.

Top module: `srvcmd_loader`

## Requirements
- R1: After synchronous reset, done_o is 0, err_o is 0, opcode_o is 0, and the next accepted byte is treated as a command byte.
- R2: A command byte whose low nibble is 1 to 7 is written unchanged to RAM address 0x31.
- R3: The k-th parameter byte of a command (k = 0 for the first) is written to RAM address 0x30 - k, so a seven-parameter command fills 0x30 down to 0x2A.
- R4: After each parameter byte, the word at 0x31 keeps its upper nibble and its low nibble equals the original count minus the number of parameters received so far.
- R5: In the cycle after the final parameter byte is taken, done_o is 1 for exactly one cycle and opcode_o carries the command code (bits 7:4 of the command byte). opcode_o is 0 whenever done_o is 0.
- R6: After a completion, the next accepted byte is again treated as a command byte.
- R7: A command byte with low nibble 0 or 8 to 15 is refused: err_o is 1 from the next cycle, RAM address 0x31 keeps its previous value, and the loader still waits for a command byte.
- R8: err_o stays 1 until a legal command byte is accepted or abort_i is asserted, and it then returns to 0.
- R9: When abort_i is 1, any byte offered in that cycle is ignored and nothing is written. A partly loaded command is dropped, and the next byte is treated as a command byte whose parameters start again at 0x30.
- R10: While byte_vld_i is 0, the value on byte_i has no effect on the RAM or on the outputs.
- R11: rd_data_o shows the RAM byte at rd_addr_i as sampled at the previous rising clock edge (one cycle of read latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| abort_i | input | 1 | Discard any partial command and wait for a command byte |
| byte_vld_i | input | 1 | byte_i holds a byte to be taken this cycle |
| byte_i | input | 8 | Incoming command or parameter byte |
| rd_addr_i | input | 6 | RAM read address |
| rd_data_o | output | 8 | RAM read data, one cycle after the address |
| done_o | output | 1 | One-cycle strobe: a complete command has been loaded |
| opcode_o | output | 4 | Command code, valid while done_o is 1, otherwise 0 |
| err_o | output | 1 | A command byte with an illegal count was refused |

## Verification
Abort and byte acceptance can fall in the same cycle. The hardest case is an abort that lines up with the final parameter byte, where a faulty priority would write the byte and fire done_o. The bench drives abort_i together with byte_vld_i on that last byte, and also at random points inside commands. It then requires no completion strobe, an unchanged parameter slot and command word in RAM, and a following command that starts its parameters again at 0x30. The outcome is judged against a bench-side model of the RAM and the sequencing state.

// File: rtl/srvcmd_pkg.sv
package srvcmd_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NIB_W    = 4;
    localparam int unsigned RAM_AW   = 6;
    localparam int unsigned MAX_PARM = 7;

    localparam logic [RAM_AW-1:0] CMD_SLOT  = 6'h31;
    localparam logic [RAM_AW-1:0] PARAM_TOP = 6'h30;

    typedef enum logic [0:0] {
        LD_WAIT_CMD   = 1'b0,
        LD_TAKE_PARAM = 1'b1
    } ld_state_e;

    typedef struct packed {
        logic [NIB_W-1:0] code;
        logic [NIB_W-1:0] left;
    } cmd_word_t;

    function automatic logic count_legal(input logic [NIB_W-1:0] n,
                                         input logic [NIB_W-1:0] max_n);
        return (n != '0) && (n <= max_n);
    endfunction

    function automatic cmd_word_t count_down(input cmd_word_t w);
        cmd_word_t r;
        r      = w;
        r.left = w.left - NIB_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/srvcmd_ram.sv
module srvcmd_ram #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Two write lanes: lane A stacks parameters, lane B holds the command word.
    always_ff @(posedge clk) begin
        if (wa_en) mem[wa_addr] <= wa_data;
        if (wb_en) mem[wb_addr] <= wb_data;
        rd_data <= mem[rd_addr];
    end

    // Parameter stack never collides with the command word slot.
    assert_lane_clash_R3: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_addr != wb_addr));

endmodule

// File: rtl/srvcmd_ptr.sv
module srvcmd_ptr #(
    parameter int unsigned        AW       = 6,
    parameter logic [AW-1:0]      TOP_ADDR = 6'h30,
    parameter int unsigned        MAX_CNT  = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          step_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] ONE      = AW'(1);
    localparam logic [AW-1:0] LOW_ADDR = TOP_ADDR - AW'(MAX_CNT - 1);

    logic [AW-1:0] ptr_q;
    logic [3:0]    used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= TOP_ADDR;
            used_q <= '0;
        end else if (load_i) begin
            ptr_q  <= TOP_ADDR;
            used_q <= '0;
        end else if (step_i) begin
            ptr_q  <= ptr_q - ONE;
            used_q <= used_q + 4'd1;
        end
    end

    assign ptr_o = ptr_q;

    // A step only ever lands on a legal parameter slot.
    assert_step_window_R3: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (ptr_q <= TOP_ADDR) && (ptr_q >= LOW_ADDR));

    // No more steps than the largest count between two loads.
    assert_step_budget_R3: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (used_q < 4'(MAX_CNT)));

endmodule

// File: rtl/srvcmd_ctrl.sv
module srvcmd_ctrl
    import srvcmd_pkg::*;
#(
    parameter int unsigned       AW       = 6,
    parameter logic [AW-1:0]     CMD_ADDR = 6'h31,
    parameter logic [AW-1:0]     TOP_ADDR = 6'h30,
    parameter int unsigned       MAX_CNT  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [AW-1:0]     ptr_i,
    output logic              load_o,
    output logic              step_o,
    output logic              wa_en_o,
    output logic [AW-1:0]     wa_addr_o,
    output logic [BYTE_W-1:0] wa_data_o,
    output logic              wb_en_o,
    output logic [AW-1:0]     wb_addr_o,
    output logic [BYTE_W-1:0] wb_data_o,
    output logic              done_o,
    output logic [NIB_W-1:0]  opcode_o,
    output logic              err_o
);
    localparam logic [NIB_W-1:0] MAX_N    = NIB_W'(MAX_CNT);
    localparam logic [NIB_W-1:0] LAST_ONE = NIB_W'(1);
    localparam logic [AW-1:0]    LOW_ADDR = TOP_ADDR - AW'(MAX_CNT - 1);

    ld_state_e        st_q, st_d;
    cmd_word_t        cur_q, cur_d;
    cmd_word_t        incoming;
    cmd_word_t        next_word;
    logic             take;
    logic             legal;
    logic             last;
    logic             done_q, done_d;
    logic [NIB_W-1:0] op_q, op_d;
    logic             err_q, err_d;

    assign incoming  = cmd_word_t'(byte_i);
    assign next_word = count_down(cur_q);
    assign take      = vld_i && !abort_i;
    assign legal     = count_legal(incoming.left, MAX_N);
    assign last      = (cur_q.left == LAST_ONE);
    assign wb_addr_o = CMD_ADDR;

    always_comb begin
        st_d      = st_q;
        cur_d     = cur_q;
        done_d    = 1'b0;
        op_d      = '0;
        err_d     = err_q;
        load_o    = 1'b0;
        step_o    = 1'b0;
        wa_en_o   = 1'b0;
        wa_addr_o = ptr_i;
        wa_data_o = byte_i;
        wb_en_o   = 1'b0;
        wb_data_o = byte_i;
        unique case (st_q)
            LD_WAIT_CMD: begin
                if (take) begin
                    if (legal) begin
                        wb_en_o = 1'b1;
                        cur_d   = incoming;
                        load_o  = 1'b1;
                        err_d   = 1'b0;
                        st_d    = LD_TAKE_PARAM;
                    end else begin
                        err_d   = 1'b1;
                    end
                end
            end
            LD_TAKE_PARAM: begin
                if (take) begin
                    wa_en_o   = 1'b1;
                    wb_en_o   = 1'b1;
                    wb_data_o = next_word;
                    cur_d     = next_word;
                    step_o    = 1'b1;
                    if (last) begin
                        done_d = 1'b1;
                        op_d   = cur_q.code;
                        st_d   = LD_WAIT_CMD;
                    end
                end
            end
        endcase
        if (abort_i) begin
            st_d  = LD_WAIT_CMD;
            err_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LD_WAIT_CMD;
            cur_q  <= '0;
            done_q <= 1'b0;
            op_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cur_q  <= cur_d;
            done_q <= done_d;
            op_q   <= op_d;
            err_q  <= err_d;
        end
    end

    assign done_o   = done_q;
    assign opcode_o = op_q;
    assign err_o    = err_q;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_opcode_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (opcode_o == '0));

    assert_last_gives_done_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == LD_TAKE_PARAM && take && last) |=> done_o);

    assert_done_back_to_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (st_q == LD_WAIT_CMD));

    assert_reject_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == LD_WAIT_CMD && take && !legal) |=> (err_o && st_q == LD_WAIT_CMD));

    assert_err_not_done_R8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !done_o);

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (st_q == LD_WAIT_CMD && !done_o && !err_o));

    assert_param_window_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == LD_TAKE_PARAM) |-> (ptr_i <= TOP_ADDR && ptr_i >= LOW_ADDR));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !vld_i |-> (!wa_en_o && !wb_en_o));

endmodule

// File: rtl/srvcmd_loader.sv
module srvcmd_loader
    import srvcmd_pkg::*;
#(
    parameter logic [RAM_AW-1:0] CMD_ADDR = CMD_SLOT,
    parameter logic [RAM_AW-1:0] TOP_ADDR = PARAM_TOP,
    parameter int unsigned       MAX_CNT  = MAX_PARM
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [RAM_AW-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              done_o,
    output logic [NIB_W-1:0]  opcode_o,
    output logic              err_o
);
    logic              load;
    logic              step;
    logic [RAM_AW-1:0] ptr;
    logic              wa_en;
    logic [RAM_AW-1:0] wa_addr;
    logic [BYTE_W-1:0] wa_data;
    logic              wb_en;
    logic [RAM_AW-1:0] wb_addr;
    logic [BYTE_W-1:0] wb_data;

    srvcmd_ctrl #(
        .AW       (RAM_AW),
        .CMD_ADDR (CMD_ADDR),
        .TOP_ADDR (TOP_ADDR),
        .MAX_CNT  (MAX_CNT)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .abort_i   (abort_i),
        .vld_i     (byte_vld_i),
        .byte_i    (byte_i),
        .ptr_i     (ptr),
        .load_o    (load),
        .step_o    (step),
        .wa_en_o   (wa_en),
        .wa_addr_o (wa_addr),
        .wa_data_o (wa_data),
        .wb_en_o   (wb_en),
        .wb_addr_o (wb_addr),
        .wb_data_o (wb_data),
        .done_o    (done_o),
        .opcode_o  (opcode_o),
        .err_o     (err_o)
    );

    srvcmd_ptr #(
        .AW       (RAM_AW),
        .TOP_ADDR (TOP_ADDR),
        .MAX_CNT  (MAX_CNT)
    ) ptr_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .step_i (step),
        .ptr_o  (ptr)
    );

    srvcmd_ram #(
        .DW (BYTE_W),
        .AW (RAM_AW)
    ) ram_i (
        .clk     (clk),
        .rst     (rst),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .wb_data (wb_data),
        .rd_addr (rd_addr_i),
        .rd_data (rd_data_o)
    );

endmodule

// File: tb/srvcmd_loader_tb_top.sv
`timescale 1ns/1ps
module srvcmd_loader_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       abort_i;
    logic       byte_vld_i;
    logic [7:0] byte_i;
    logic [5:0] rd_addr_i;
    logic [7:0] rd_data_o;
    logic       done_o;
    logic [3:0] opcode_o;
    logic       err_o;

    always #2 clk = ~clk;

    srvcmd_loader dut_i (
        .clk        (clk),
        .rst        (rst),
        .abort_i    (abort_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .done_o     (done_o),
        .opcode_o   (opcode_o),
        .err_o      (err_o)
    );

    int  total = 0;
    int  bad   = 0;
    bit  ended = 0;

    // Reference model
    logic [7:0] m_mem   [64];
    bit         m_known [64];
    bit         m_busy;
    logic [3:0] m_code;
    logic [3:0] m_left;
    logic [5:0] m_ptr;
    bit         m_err;
    bit         m_done;
    logic [3:0] m_op;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit legal_count(input logic [3:0] n);
        return (n >= 4'd1) && (n <= 4'd7);
    endfunction

    function automatic void model_step(input logic [7:0] b, input bit ab);
        m_done = 0;
        m_op   = 4'd0;
        if (ab) begin
            m_busy = 0;
            m_err  = 0;
        end else if (!m_busy) begin
            if (legal_count(b[3:0])) begin
                m_mem[6'h31] = b; m_known[6'h31] = 1;
                m_code = b[7:4]; m_left = b[3:0];
                m_ptr  = 6'h30;  m_busy = 1; m_err = 0;
            end else begin
                m_err = 1;
            end
        end else begin
            m_mem[m_ptr] = b; m_known[m_ptr] = 1;
            m_left = m_left - 4'd1;
            m_mem[6'h31] = {m_code, m_left};
            m_ptr = m_ptr - 6'd1;
            if (m_left == 4'd0) begin
                m_done = 1; m_op = m_code; m_busy = 0;
            end
        end
    endfunction

    // Offers one byte for one edge, then checks the outputs that edge produced.
    task automatic send(input logic [7:0] b, input bit ab, input string req);
        @(negedge clk);
        byte_vld_i = 1'b1;
        byte_i     = b;
        abort_i    = ab;
        model_step(b, ab);
        @(negedge clk);
        byte_vld_i = 1'b0;
        abort_i    = 1'b0;
        byte_i     = $urandom();
        chk(done_o == m_done, req, "done_o", int'(done_o), int'(m_done));
        chk(opcode_o == m_op, "R5", "opcode_o", int'(opcode_o), int'(m_op));
        chk(err_o == m_err, "R7/R8", "err_o", int'(err_o), int'(m_err));
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_addr_i = a;
        @(negedge clk);
        chk(rd_data_o == exp, req, $sformatf("ram[0x%0h]", a), int'(rd_data_o), int'(exp));
    endtask

    task automatic ram_sweep();
        for (int a = 6'h2A; a <= 6'h31; a++) begin
            if (m_known[a]) rd_check(6'(a), m_mem[a], (a == 6'h31) ? "R4" : "R3");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h5EED_0784);
        for (int i = 0; i < 64; i++) begin m_known[i] = 0; m_mem[i] = 8'h00; end
        m_busy = 0; m_err = 0; m_code = 0; m_left = 0; m_ptr = 6'h30;
        rst = 1'b1; abort_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00; rd_addr_i = 6'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(done_o == 1'b0, "R1", "done_o", int'(done_o), 0);
        chk(err_o == 1'b0, "R1", "err_o", int'(err_o), 0);
        chk(opcode_o == 4'd0, "R1", "opcode_o", int'(opcode_o), 0);

        // R2: command byte stored verbatim
        send(8'h53, 0, "R2");
        rd_check(6'h31, 8'h53, "R2");
        // R3/R4: first parameter and count decrement
        send(8'hA1, 0, "R3");
        rd_check(6'h31, 8'h52, "R4");
        rd_check(6'h30, 8'hA1, "R3");
        send(8'hB2, 0, "R4");
        send(8'hC3, 0, "R5");
        chk(opcode_o == 4'h5, "R5", "opcode on done", int'(opcode_o), 5);
        @(negedge clk);
        chk(done_o == 1'b0, "R5", "done width", int'(done_o), 0);
        ram_sweep();

        // R11: one cycle of read latency
        @(negedge clk);
        rd_addr_i = 6'h31;
        @(negedge clk);
        rd_addr_i = 6'h30;
        chk(rd_data_o == m_mem[6'h31], "R11", "before edge", int'(rd_data_o), int'(m_mem[6'h31]));
        @(negedge clk);
        chk(rd_data_o == m_mem[6'h30], "R11", "after edge", int'(rd_data_o), int'(m_mem[6'h30]));

        // R7: illegal counts refused, command slot untouched
        send(8'h90, 0, "R7");
        rd_check(6'h31, m_mem[6'h31], "R7");
        send(8'h4F, 0, "R7");
        send(8'h28, 0, "R7");
        // R8: legal command clears error; R6: after done, command again
        send(8'h71, 0, "R8");
        send(8'h11, 0, "R5");
        send(8'h62, 0, "R6");
        send(8'hD0, 0, "R3");
        send(8'hD1, 0, "R6");
        ram_sweep();

        // R9: abort in the middle, then restart at 0x30
        send(8'h24, 0, "R9");
        send(8'h01, 0, "R9");
        send(8'h02, 1, "R9");
        send(8'h61, 0, "R9");
        send(8'hEE, 0, "R9");
        rd_check(6'h30, 8'hEE, "R9");
        // R9: abort coinciding with the final parameter
        send(8'h32, 0, "R9");
        send(8'hAA, 0, "R9");
        send(8'hBB, 1, "R9");
        rd_check(6'h2F, m_mem[6'h2F], "R9");
        rd_check(6'h31, 8'h31, "R9");
        // R8: abort clears error
        send(8'h00, 0, "R7");
        send(8'h00, 1, "R8");

        // R10: junk bytes with valid low change nothing
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_i = $urandom();
            chk(done_o == 1'b0, "R10", "done_o idle", int'(done_o), 0);
        end
        ram_sweep();

        // Maximum count fills down to 0x2A
        send(8'h87, 0, "R2");
        for (int i = 0; i < 7; i++) send(8'h10 + 8'(i), 0, "R3");
        rd_check(6'h2A, 8'h16, "R3");
        ram_sweep();

        // Random commands with occasional bad counts and aborts
        for (int c = 0; c < 150; c++) begin
            logic [3:0] n;
            int unsigned pick;
            pick = $urandom_range(0, 9);
            if (pick == 0) n = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(8, 15));
            else n = 4'($urandom_range(1, 7));
            send({4'($urandom()), n}, ($urandom_range(0, 19) == 0), "R6");
            for (int p = 0; p < int'(n) && p < 7; p++)
                send(8'($urandom()), ($urandom_range(0, 14) == 0), "R5");
            if (c % 10 == 0) ram_sweep();
        end
        ram_sweep();

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule